// File: doc/BRIEF.md
# Strip-Mining Vector Length Sequencer

This block cuts a loop of `n` elements into pieces that each fit in a vector register of at most `m` elements. Each piece is described by a start index and a length. After a start pulse it works out `n mod m` and issues that short, odd-sized piece first. Every later piece is a full `m`, so the downstream vector unit sees one partial piece up front, followed by a run of full-width pieces.

Pieces leave one at a time over a valid/ready handshake. A piece stays on the outputs until it is taken. After the last piece is taken, a one-cycle done pulse follows. Two versions of the remainder unit are available, chosen by a parameter. One is a serial restoring unit that needs one cycle per bit of `n`. The other computes the remainder combinationally in one cycle.

Top module: `vl_strip_seq`

## Requirements
- R1: With n > 0 and effective maximum length m, the first piece has start index 0 and length n mod m. When n mod m is 0, the first piece has length m instead, so no piece of length 0 is ever issued.
- R2: Every piece after the first has length m. Its start index equals the previous piece's start index plus the previous piece's length.
- R3: Over one run, the lengths of all issued pieces add up to n. The number of pieces is n/m rounded up.
- R4: While `vec_valid_o` is 1 and `vec_ready_i` is 0, `vec_valid_o`, `vec_base_o` and `vec_len_o` hold their values into the next cycle. A piece is transferred on a clock edge where both are 1.
- R5: `run_done_o` is 1 for exactly the one cycle after the edge that transfers the last piece. `vec_valid_o` is 0 in that cycle.
- R6: When a start is accepted with n = 0, no piece is issued and `run_done_o` is 1 in the cycle after the accepting edge.
- R7: A start pulse is ignored from the edge that accepts a start until the run's done cycle. This includes a start that arrives on the edge of the last transfer. Such a pulse changes neither the pieces of the current run nor the values latched for n and m.
- R8: A value of `max_len_i` that is 0 or above MVL_MAX is treated as m = MVL_MAX. Values from 1 to MVL_MAX are used as given.
- R9: While `rst_n` is low, `vec_valid_o` and `run_done_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse; sampled only when idle |
| elem_cnt_i | input | CNT_W | Total element count n, sampled with start |
| max_len_i | input | $clog2(MVL_MAX+1) | Requested maximum piece length, sampled with start |
| vec_ready_i | input | 1 | Downstream accepts the current piece |
| vec_valid_o | output | 1 | A piece is presented |
| vec_base_o | output | CNT_W | Start index of the presented piece |
| vec_len_o | output | $clog2(MVL_MAX+1) | Length of the presented piece |
| run_done_o | output | 1 | One-cycle pulse after the last piece is taken |

## Verification
Two events can fall in the same clock edge:
- the acceptance of the final piece, and
- a fresh start pulse.

The bench provokes this by raising `start_i` in the same cycle it raises `vec_ready_i` for the last piece. It then checks three things:
- the done pulse appears in the following cycle;
- no further piece appears for thirty cycles;
- the pulse therefore counted as arriving while busy.

A second case pulses start, with a different count, while the remainder is still being computed. It then checks that the pieces still follow the first count.

// File: rtl/vlss_pkg.sv
package vlss_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_DIV   = 2'd1,
      ST_ISSUE = 2'd2
   } vlss_state_e;
endpackage

// File: rtl/vlss_mvl_clamp.sv
module vlss_mvl_clamp #(
   parameter int MVL_MAX = 64,
   localparam int LEN_W = $clog2(MVL_MAX + 1)
) (
   input  logic [LEN_W-1:0] raw_i,
   output logic [LEN_W-1:0] eff_o
);
   localparam logic [LEN_W-1:0] LIMIT = LEN_W'(MVL_MAX);

   // R8: out-of-range requests fall back to the parameter bound
   always_comb begin
      if (raw_i == '0 || raw_i > LIMIT) eff_o = LIMIT;
      else                              eff_o = raw_i;
   end
endmodule

// File: rtl/vlss_remdiv.sv
module vlss_remdiv #(
   parameter int NUM_W = 16,
   parameter int DEN_W = 7,
   parameter bit SEQ   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go_i,
   input  logic [NUM_W-1:0] num_i,
   input  logic [DEN_W-1:0] den_i,
   output logic             done_o,
   output logic [DEN_W-1:0] rem_o
);
   localparam int STEP_W = $clog2(NUM_W + 1);

   if (NUM_W < DEN_W) begin : g_bad_width
      $error("vlss_remdiv: NUM_W must be at least DEN_W");
   end

   if (SEQ) begin : g_seq
      logic [DEN_W-1:0]  den_q;
      logic [DEN_W-1:0]  rem_q;
      logic [NUM_W-1:0]  sh_q;
      logic [STEP_W-1:0] step_q;
      logic              run_q;
      logic              done_q;
      logic [DEN_W:0]    trial;

      assign trial = {rem_q, sh_q[NUM_W-1]};

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            den_q  <= '0;
            rem_q  <= '0;
            sh_q   <= '0;
            step_q <= '0;
            run_q  <= 1'b0;
            done_q <= 1'b0;
         end else begin
            done_q <= 1'b0;
            if (go_i) begin
               den_q  <= den_i;
               rem_q  <= '0;
               sh_q   <= num_i;
               step_q <= STEP_W'(NUM_W);
               run_q  <= 1'b1;
            end else if (run_q) begin
               if (trial >= {1'b0, den_q}) rem_q <= DEN_W'(trial - {1'b0, den_q});
               else                        rem_q <= trial[DEN_W-1:0];
               sh_q   <= sh_q << 1;
               step_q <= step_q - 1'b1;
               if (step_q == STEP_W'(1)) begin
                  run_q  <= 1'b0;
                  done_q <= 1'b1;
               end
            end
         end
      end

      assign done_o = done_q;
      assign rem_o  = rem_q;

      // R1
      rem_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
         done_q |-> (rem_q < den_q));
   end else begin : g_comb
      logic [DEN_W-1:0] rem_q;
      logic             done_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rem_q  <= '0;
            done_q <= 1'b0;
         end else begin
            done_q <= go_i;
            if (go_i) rem_q <= DEN_W'(num_i % NUM_W'(den_i));
         end
      end

      assign done_o = done_q;
      assign rem_o  = rem_q;
   end
endmodule

// File: rtl/vl_strip_seq.sv
module vl_strip_seq
   import vlss_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter int MVL_MAX = 64,
   parameter bit SEQ_DIV = 1'b1,
   localparam int LEN_W  = $clog2(MVL_MAX + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [CNT_W-1:0] elem_cnt_i,
   input  logic [LEN_W-1:0] max_len_i,
   input  logic             vec_ready_i,
   output logic             vec_valid_o,
   output logic [CNT_W-1:0] vec_base_o,
   output logic [LEN_W-1:0] vec_len_o,
   output logic             run_done_o
);
   if (MVL_MAX < 1) begin : g_bad_mvl
      $error("vl_strip_seq: MVL_MAX must be at least 1");
   end
   if (CNT_W < LEN_W) begin : g_bad_cnt
      $error("vl_strip_seq: CNT_W must cover the length width");
   end

   vlss_state_e      state_q;
   logic [CNT_W-1:0] total_q;
   logic [LEN_W-1:0] mvl_q;
   logic [CNT_W-1:0] base_q;
   logic [LEN_W-1:0] len_q;
   logic [CNT_W-1:0] left_q;
   logic             valid_q;
   logic             done_q;

   logic [LEN_W-1:0] mvl_eff;
   logic             div_go;
   logic             div_done;
   logic [LEN_W-1:0] div_rem;
   logic [LEN_W-1:0] first_len;

   vlss_mvl_clamp #(.MVL_MAX(MVL_MAX)) clamp_i (
      .raw_i (max_len_i),
      .eff_o (mvl_eff)
   );

   assign div_go = (state_q == ST_IDLE) && start_i && (elem_cnt_i != '0);

   vlss_remdiv #(.NUM_W(CNT_W), .DEN_W(LEN_W), .SEQ(SEQ_DIV)) div_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .go_i   (div_go),
      .num_i  (elem_cnt_i),
      .den_i  (mvl_eff),
      .done_o (div_done),
      .rem_o  (div_rem)
   );

   // zero remainder means the short piece vanishes and a full one leads
   assign first_len = (div_rem == '0) ? mvl_q : div_rem;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         total_q <= '0;
         mvl_q   <= LEN_W'(MVL_MAX);
         base_q  <= '0;
         len_q   <= '0;
         left_q  <= '0;
         valid_q <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  total_q <= elem_cnt_i;
                  mvl_q   <= mvl_eff;
                  if (elem_cnt_i == '0) done_q  <= 1'b1;
                  else                  state_q <= ST_DIV;
               end
            end
            ST_DIV: begin
               if (div_done) begin
                  base_q  <= '0;
                  len_q   <= first_len;
                  left_q  <= total_q - CNT_W'(first_len);
                  valid_q <= 1'b1;
                  state_q <= ST_ISSUE;
               end
            end
            ST_ISSUE: begin
               if (vec_ready_i) begin
                  if (left_q == '0) begin
                     valid_q <= 1'b0;
                     done_q  <= 1'b1;
                     state_q <= ST_IDLE;
                  end else begin
                     base_q <= base_q + CNT_W'(len_q);
                     len_q  <= mvl_q;
                     left_q <= left_q - CNT_W'(mvl_q);
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign vec_valid_o = valid_q;
   assign vec_base_o  = base_q;
   assign vec_len_o   = len_q;
   assign run_done_o  = done_q;

   // R4
   hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_q && !vec_ready_i) |=> (valid_q && $stable(base_q) && $stable(len_q)));

   // R1
   len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_q |-> (len_q != '0 && len_q <= mvl_q));

   // R8
   mvl_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mvl_q != '0) && (mvl_q <= LEN_W'(MVL_MAX)));

   // R2
   base_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_q && vec_ready_i && left_q != '0) |=>
         (valid_q && len_q == mvl_q &&
          base_q == ($past(base_q) + CNT_W'($past(len_q)))));

   // R5
   done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> !valid_q);

   // R6
   zero_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE && start_i && elem_cnt_i == '0) |=> (done_q && !valid_q));

   // R7
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_IDLE) |=> ($stable(total_q) && $stable(mvl_q)));
endmodule

// File: tb/vl_strip_seq_tb.sv
module vl_strip_seq_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int CNT_W      = 16;
   localparam int MVL_MAX    = 64;
   localparam int LEN_W      = $clog2(MVL_MAX + 1);
   localparam int NVEC       = 11;

   // n, requested length, mode (0 ready, 1 stalls, 2 start on last, 3 start while busy)
   localparam int VEC_N    [NVEC] = '{10, 12, 3, 64, 65, 1, 7, 200, 5, 9, 65535};
   localparam int VEC_M    [NVEC] = '{4,  4,  8, 64, 64, 1, 0, 100, 3, 4, 64};
   localparam int VEC_MODE [NVEC] = '{0,  1,  0, 1,  0,  1, 0, 1,   2, 3, 0};

   logic             clk = 1'b0;
   logic             rst_n;
   logic             start;
   logic [CNT_W-1:0] total;
   logic [LEN_W-1:0] mvl;
   logic             rdy;
   logic             vld;
   logic [CNT_W-1:0] base;
   logic [LEN_W-1:0] len;
   logic             done;

   int checks   = 0;
   int failures = 0;
   int cycles   = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   vl_strip_seq #(.CNT_W(CNT_W), .MVL_MAX(MVL_MAX), .SEQ_DIV(1'b1)) dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start),
      .elem_cnt_i  (total),
      .max_len_i   (mvl),
      .vec_ready_i (rdy),
      .vec_valid_o (vld),
      .vec_base_o  (base),
      .vec_len_o   (len),
      .run_done_o  (done)
   );

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         failures++;
         $display("FAIL R3 watchdog expired act=%0d exp=%0d", cycles, 150000);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic check(input bit ok, input string what, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s act=%0d exp=%0d", what, act, exp);
      end
   endtask

   task automatic run_case(input int n, input int mraw, input int mode);
      int m, rem, first, exp_cnt, k, sum, cyc, eb, el;
      bit pv, pr, fin;
      logic [CNT_W-1:0] pb;
      logic [LEN_W-1:0] pl;
      m       = (mraw == 0 || mraw > MVL_MAX) ? MVL_MAX : mraw;
      rem     = n % m;
      first   = (rem != 0) ? rem : m;
      exp_cnt = (n == 0) ? 0 : ((rem != 0) ? n / m + 1 : n / m);

      @(negedge clk);
      total = CNT_W'(n);
      mvl   = LEN_W'(mraw);
      start = 1'b1;
      rdy   = 1'b0;
      @(negedge clk);
      start = 1'b0;

      if (n == 0) begin
         check(done === 1'b1 && vld === 1'b0, "R6 zero count done next cycle", done, 1);
         @(negedge clk);
         check(done === 1'b0 && vld === 1'b0, "R6 zero count single pulse", done, 0);
         return;
      end

      k = 0; sum = 0; cyc = 0; fin = 0; pv = 0; pr = 0; pb = '0; pl = '0;
      while (!fin && cyc < 6000) begin
         cyc++;
         if (mode == 3 && cyc == 2) begin
            total = CNT_W'(n + 3);
            start = 1'b1;
         end else begin
            start = 1'b0;
         end
         if (pv && !pr)
            check(vld === 1'b1 && base == pb && len == pl, "R4 held piece changed", base, pb);
         rdy = (mode == 1) ? (cyc % 3 != 0) : 1'b1;
         if (vld && rdy) begin
            eb = (k == 0) ? 0 : first + (k - 1) * m;
            el = (k == 0) ? first : m;
            if (k == 0) check(base == eb && len == el, "R1 first piece length", len, el);
            else        check(base == eb && len == el, "R2 later piece base", base, eb);
            sum += int'(len);
            k++;
            if (k == exp_cnt) begin
               fin = 1;
               if (mode == 2) start = 1'b1;
            end
         end
         pv = vld; pr = rdy; pb = base; pl = len;
         @(negedge clk);
      end
      start = 1'b0;
      rdy   = 1'b0;
      check(fin, "R3 run did not finish", k, exp_cnt);
      check(done === 1'b1 && vld === 1'b0, "R5 done after last transfer", done, 1);
      check(k == exp_cnt, "R3 piece count", k, exp_cnt);
      check(sum == n, "R3 sum of lengths", sum, n);
      @(negedge clk);
      check(done === 1'b0, "R5 done single cycle", done, 0);
      if (mode == 2) begin
         for (int i = 0; i < 30; i++) begin
            if (vld !== 1'b0) check(1'b0, "R7 start on last edge accepted", vld, 0);
            @(negedge clk);
         end
         check(vld === 1'b0 && done === 1'b0, "R7 no new run after collision", vld, 0);
      end
   endtask

   initial begin
      rst_n = 1'b0;
      start = 1'b0;
      total = '0;
      mvl   = '0;
      rdy   = 1'b0;
      repeat (3) @(negedge clk);
      check(vld === 1'b0 && done === 1'b0, "R9 reset outputs", vld, 0);
      rst_n = 1'b1;

      for (int v = 0; v < NVEC; v++) run_case(VEC_N[v], VEC_M[v], VEC_MODE[v]);

      // R6 zero count, R8 clamp of a zero request with zero count
      run_case(0, 5, 0);
      run_case(0, 0, 0);
      // R8 request above bound
      run_case(130, 100, 0);

      for (int i = 0; i < 40; i++)
         run_case(int'($urandom_range(0, 300)), int'($urandom_range(1, MVL_MAX)), i % 2);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule